// File: doc/BRIEF.md
# Programmable Synchronous Memory Bus Controller

The controller connects a simple host request port to an external synchronous memory: a pipelined burst SRAM, a zero-turnaround SRAM, or a synchronous FIFO reached through glue logic. The host presents a burst of one to four words with a starting word address, a byte-enable mask and, for writes, all of the write words at once. The controller then issues one command per clock on the memory side, moves the data after a programmable number of cycles, and returns read words to the host with a one-cycle valid strobe.

Four configuration inputs set the cycle behaviour: read latency (0 to 3), write latency (0 to 3), a chip-enable extension bit that keeps the chip selected while read data is being taken, and a strobe-mode bit. When the strobe-mode bit is clear, the shared strobe pin acts as an address strobe and one deselect cycle follows each burst. When it is set, the pin acts as a FIFO read enable and no deselect cycle is added. The configuration is captured when a burst is accepted, so it can be changed freely between bursts. All memory-side controls and byte enables are active low and come straight from flops.

Top module: `psmc_top`

## Requirements
- R1: After reset, mem_ce_n, mem_strb_n, mem_oe_n, mem_we_n are 1, mem_be_n is 4'hF, busy and rd_valid are 0, and the controller does not drive mem_data.
- R2: A request accepted at a clock edge (req_valid high, busy low) with req_len = k issues N = k+1 commands in bus cycles 0..N-1 after that edge; in command cycle i, mem_strb_n is 0, mem_addr is req_addr+i (modulo 2^20) and mem_be_n is the bitwise inverse of req_be.
- R3: For a read with read latency L, mem_oe_n is 0 exactly in bus cycles L..N+L-1; the word on mem_data in cycle i+L is returned as rd_data with rd_valid high in cycle i+L+1, in beat order, and rd_valid is 0 otherwise.
- R4: For a write with write latency L, mem_we_n is 0 exactly in the command cycles, mem_oe_n stays 1, and host word i (req_wdata bits 32i+31..32i) is driven on mem_data in bus cycle i+L.
- R5: With the chip-enable extension bit clear, mem_ce_n is 0 only in command cycles.
- R6: With the chip-enable extension bit set, mem_ce_n is 0 in command cycles and additionally in every cycle where mem_oe_n is 0.
- R7: With the strobe-mode bit clear, bus cycle N is a deselect cycle (mem_strb_n 0, mem_ce_n 1) unless the chip enable is held low by R6 in that cycle, in which case mem_strb_n stays 1; with the bit set, mem_strb_n is 0 only in command cycles.
- R8: busy is 1 for exactly T = N + max(L, s) bus cycles after acceptance, where s is 1 in address-strobe mode and 0 in read-enable mode; a request presented while busy is 1 is ignored.
- R9: The configuration inputs are sampled only at the accepting edge; changing them during a burst does not alter that burst.
- R10: mem_data is driven by the controller only in write data cycles and never in a cycle where mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_lat | input | 2 | Read latency in cycles |
| cfg_wr_lat | input | 2 | Write latency in cycles |
| cfg_ce_hold | input | 1 | Keep chip enable low while output enable is low |
| cfg_rden_mode | input | 1 | 1: strobe is FIFO read enable, 0: address strobe with deselect |
| req_valid | input | 1 | Burst request |
| req_write | input | 1 | 1 write, 0 read |
| req_len | input | 2 | Beats minus one |
| req_addr | input | 20 | Starting word address |
| req_be | input | 4 | Byte enables, active high, for every beat |
| req_wdata | input | 128 | Write words, word 0 in the low bits |
| busy | output | 1 | Burst in progress |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_strb_n | output | 1 | Address strobe or read enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 20 | Word address |
| mem_be_n | output | 4 | Byte enables, active low |
| mem_data | inout | 32 | Bidirectional data bus |

## Verification
Every combination of direction, burst length (1 to 4 beats), latency (0 to 3) and both mode bits is run, which separates an off-by-one in the latency pipe from a wrong burst count and shows each mode bit acting alone and together. Start addresses near the top of the address space expose a missing wrap of the beat address, and a different byte-enable mask per burst exposes a stuck polarity. During every burst the configuration inputs are inverted and a stray request is pulsed, so a controller that samples settings late or accepts work while busy produces a visibly different bus pattern.

// File: rtl/psmc_pkg.sv
package psmc_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int BE_W   = 4;
    localparam int LEN_W  = 2;
    localparam int LAT_W  = 2;
    localparam int BEATS  = 1 << LEN_W;
    localparam int CNT_W  = LEN_W + LAT_W;

    typedef struct packed {
        logic [LAT_W-1:0] rd_lat;
        logic [LAT_W-1:0] wr_lat;
        logic             ce_hold;
        logic             rden_mode;
    } cfg_t;

    typedef struct packed {
        logic                         wr;
        logic [LEN_W-1:0]             len;
        logic [ADDR_W-1:0]            addr;
        logic [BE_W-1:0]              be;
        logic [BEATS-1:0][DATA_W-1:0] wdata;
        cfg_t                         cfg;
    } burst_t;

    typedef struct packed {
        logic              ce_n;
        logic              strb_n;
        logic              oe_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be_n;
        logic              drv;
        logic [LEN_W-1:0]  wbeat;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, strb_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                    addr: '0, be_n: '1, drv: 1'b0, wbeat: '0};

    function automatic logic [CNT_W-1:0] beats_of(burst_t b);
        return CNT_W'(b.len) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] lat_of(burst_t b);
        return b.wr ? CNT_W'(b.cfg.wr_lat) : CNT_W'(b.cfg.rd_lat);
    endfunction

    // Cycles a burst occupies: commands plus the longer of latency tail and deselect slot.
    function automatic logic [CNT_W-1:0] span_of(burst_t b);
        logic [CNT_W-1:0] tail;
        tail = lat_of(b);
        if (tail == '0 && !b.cfg.rden_mode) tail = CNT_W'(1);
        return beats_of(b) + tail;
    endfunction

    function automatic pins_t pins_at(burst_t b, logic act, logic [CNT_W-1:0] t);
        pins_t            p;
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] l;
        logic             cmd;
        logic             dphase;
        logic             rphase;
        logic             held;
        logic             desel;
        p = PINS_IDLE;
        if (act) begin
            n      = beats_of(b);
            l      = lat_of(b);
            cmd    = t < n;
            dphase = (t >= l) && (t < n + l);
            rphase = !b.wr && dphase;
            held   = b.cfg.ce_hold && rphase;
            desel  = !b.cfg.rden_mode && (t == n) && !held;
            p.ce_n   = !(cmd || held);
            p.strb_n = !(cmd || desel);
            p.oe_n   = !rphase;
            p.we_n   = !(b.wr && cmd);
            if (cmd) begin
                p.addr = b.addr + ADDR_W'(t);
                p.be_n = ~b.be;
            end
            p.drv   = b.wr && dphase;
            p.wbeat = LEN_W'(t - l);
        end
        return p;
    endfunction
endpackage

// File: rtl/psmc_seq.sv
module psmc_seq
    import psmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  burst_t           req_b,
    output logic             busy,
    output burst_t           b_nx,
    output logic             act_nx,
    output logic [CNT_W-1:0] t_nx
);
    burst_t           b_q;
    logic             active;
    logic [CNT_W-1:0] t_q;

    always_comb begin
        b_nx   = b_q;
        act_nx = active;
        t_nx   = t_q;
        if (active) begin
            t_nx   = t_q + CNT_W'(1);
            act_nx = (t_q + CNT_W'(1)) < span_of(b_q);
        end else if (req_valid) begin
            b_nx   = req_b;
            act_nx = 1'b1;
            t_nx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q    <= '0;
            active <= 1'b0;
            t_q    <= '0;
        end else begin
            b_q    <= b_nx;
            active <= act_nx;
            t_q    <= t_nx;
        end
    end

    assign busy = active;

    // R8: a request during a burst leaves the captured burst untouched
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(b_q));
    // R8: the cycle index never runs past the burst span
    p_span_bound_r8: assert property (@(posedge clk) disable iff (rst)
        active |-> (t_q < span_of(b_q)));
endmodule

// File: rtl/psmc_bus.sv
module psmc_bus
    import psmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  burst_t            b_nx,
    input  logic              act_nx,
    input  logic [CNT_W-1:0]  t_nx,
    output logic              ce_n,
    output logic              strb_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BE_W-1:0]   be_n,
    output logic              drv,
    output logic [DATA_W-1:0] dout
);
    pins_t p_nx;
    pins_t p_q;
    logic [DATA_W-1:0] dout_q;

    always_comb p_nx = pins_at(b_nx, act_nx, t_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q    <= PINS_IDLE;
            dout_q <= '0;
        end else begin
            p_q    <= p_nx;
            dout_q <= p_nx.drv ? b_nx.wdata[p_nx.wbeat] : '0;
        end
    end

    assign ce_n   = p_q.ce_n;
    assign strb_n = p_q.strb_n;
    assign oe_n   = p_q.oe_n;
    assign we_n   = p_q.we_n;
    assign addr   = p_q.addr;
    assign be_n   = p_q.be_n;
    assign drv    = p_q.drv;
    assign dout   = dout_q;

    // R10: the controller never drives the bus while the memory is enabled to drive it
    p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
        drv |-> oe_n);
    // R4: write and output enables are never low together
    p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));
endmodule

// File: rtl/psmc_rdcap.sv
module psmc_rdcap
    import psmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= !oe_n;
            if (!oe_n) rd_data <= bus_in;
        end
    end

    // R3: every output-enable cycle yields one returned word on the next cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        !oe_n |=> rd_valid);
    // R3: no returned word without a preceding output-enable cycle
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !rd_valid);
endmodule

// File: rtl/psmc_top.sv
module psmc_top
    import psmc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LAT_W-1:0]        cfg_rd_lat,
    input  logic [LAT_W-1:0]        cfg_wr_lat,
    input  logic                    cfg_ce_hold,
    input  logic                    cfg_rden_mode,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [BE_W-1:0]         req_be,
    input  logic [BEATS*DATA_W-1:0] req_wdata,
    output logic                    busy,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    mem_ce_n,
    output logic                    mem_strb_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BE_W-1:0]         mem_be_n,
    inout  wire  [DATA_W-1:0]       mem_data
);
    burst_t            req_b;
    burst_t            b_nx;
    logic              act_nx;
    logic [CNT_W-1:0]  t_nx;
    logic              drv;
    logic [DATA_W-1:0] dout;

    always_comb begin
        req_b               = '0;
        req_b.wr            = req_write;
        req_b.len           = req_len;
        req_b.addr          = req_addr;
        req_b.be            = req_be;
        req_b.wdata         = req_wdata;
        req_b.cfg.rd_lat    = cfg_rd_lat;
        req_b.cfg.wr_lat    = cfg_wr_lat;
        req_b.cfg.ce_hold   = cfg_ce_hold;
        req_b.cfg.rden_mode = cfg_rden_mode;
    end

    psmc_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_b(req_b),
        .busy(busy), .b_nx(b_nx), .act_nx(act_nx), .t_nx(t_nx)
    );

    psmc_bus u_bus (
        .clk(clk), .rst(rst), .b_nx(b_nx), .act_nx(act_nx), .t_nx(t_nx),
        .ce_n(mem_ce_n), .strb_n(mem_strb_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .addr(mem_addr), .be_n(mem_be_n), .drv(drv), .dout(dout)
    );

    psmc_rdcap u_rdcap (
        .clk(clk), .rst(rst), .oe_n(mem_oe_n), .bus_in(mem_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign mem_data = drv ? dout : {DATA_W{1'bz}};
endmodule

// File: tb/psmc_top_tb_top.sv
module psmc_top_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_rd_lat = '0;
    logic [1:0]   cfg_wr_lat = '0;
    logic         cfg_ce_hold = 1'b0;
    logic         cfg_rden_mode = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_len = '0;
    logic [19:0]  req_addr = '0;
    logic [3:0]   req_be = '0;
    logic [127:0] req_wdata = '0;
    logic         busy;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         mem_ce_n, mem_strb_n, mem_oe_n, mem_we_n;
    logic [19:0]  mem_addr;
    logic [3:0]   mem_be_n;
    wire  [31:0]  mem_data;

    int n_checks = 0;
    int n_fail   = 0;
    int burst_id = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    psmc_top dut_i (
        .clk(clk), .rst(rst), .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .cfg_ce_hold(cfg_ce_hold), .cfg_rden_mode(cfg_rden_mode),
        .req_valid(req_valid), .req_write(req_write), .req_len(req_len),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_strb_n(mem_strb_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_data(mem_data)
    );

    // Memory model: returns a value derived from the address given L cycles earlier.
    logic [19:0] ad1, ad2, ad3, model_addr;
    logic [1:0]  model_lat = '0;
    always @(posedge clk) begin
        ad1 <= mem_addr;
        ad2 <= ad1;
        ad3 <= ad2;
    end
    always_comb begin
        case (model_lat)
            2'd0:    model_addr = mem_addr;
            2'd1:    model_addr = ad1;
            2'd2:    model_addr = ad2;
            default: model_addr = ad3;
        endcase
    end
    function automatic logic [31:0] mem_word(logic [19:0] a);
        return {12'h3C5, a};
    endfunction
    assign mem_data = !mem_oe_n ? mem_word(model_addr) : 32'bz;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (burst %0d, t=%0d)", tag, act, exp, burst_id, 0);
        end
    endtask

    task automatic run_burst(input bit wr, input int n, input int lat, input bit hold, input bit fifo,
                             input logic [19:0] base, input logic [3:0] be);
        int          span;
        int          ngot;
        int          bad;
        logic [31:0] got [4];
        logic [31:0] wexp [4];
        bit          cmd, dp, desel;
        bit          e_ce, e_strb, e_oe, e_we;
        span = n + ((lat == 0 && !fifo) ? 1 : lat);
        for (int i = 0; i < 4; i++) wexp[i] = 32'h5A000000 | (burst_id << 8) | i;
        ngot = 0;
        bad  = 0;
        // present request at this negedge
        req_valid     = 1'b1;
        req_write     = wr;
        req_len       = 2'(n - 1);
        req_addr      = base;
        req_be        = be;
        req_wdata     = {wexp[3], wexp[2], wexp[1], wexp[0]};
        cfg_rd_lat    = 2'(lat);
        cfg_wr_lat    = 2'(lat);
        cfg_ce_hold   = hold;
        cfg_rden_mode = fifo;
        model_lat     = 2'(lat);
        for (int t = 0; t <= span; t++) begin
            @(negedge clk);
            if (t == 0) begin
                req_valid     = 1'b0;
                // R9: configuration scrambled right after acceptance
                cfg_rd_lat    = ~2'(lat);
                cfg_wr_lat    = 2'(lat + 1);
                cfg_ce_hold   = !hold;
                cfg_rden_mode = !fifo;
            end
            cmd    = t < n;
            dp     = (t >= lat) && (t < n + lat);
            e_oe   = !(!wr && dp);
            e_ce   = !(cmd || (hold && !wr && dp));
            desel  = !fifo && (t == n) && !(hold && !wr && dp);
            e_strb = !(cmd || desel);
            e_we   = !(wr && cmd);
            if (busy !== (t < span)) bad++;
            chk(busy === (t < span), "R8 busy window", 64'(busy), 64'(t < span));
            chk(mem_ce_n === e_ce, hold ? "R6 chip enable held" : "R5 chip enable", 64'(mem_ce_n), 64'(e_ce));
            if (mem_ce_n !== e_ce) bad++;
            chk(mem_strb_n === e_strb, fifo ? "R7 read-enable strobe" : "R7 address strobe/deselect",
                64'(mem_strb_n), 64'(e_strb));
            if (mem_strb_n !== e_strb) bad++;
            chk(mem_oe_n === e_oe, "R3 output enable", 64'(mem_oe_n), 64'(e_oe));
            if (mem_oe_n !== e_oe) bad++;
            chk(mem_we_n === e_we, "R4 write enable", 64'(mem_we_n), 64'(e_we));
            if (mem_we_n !== e_we) bad++;
            if (cmd) begin
                chk(mem_addr === base + 20'(t), "R2 command address", 64'(mem_addr), 64'(base + 20'(t)));
                chk(mem_be_n === ~be, "R2 byte enables", 64'(mem_be_n), 64'(~be));
            end
            if (wr && dp) begin
                chk(mem_data === wexp[t - lat], "R4 R10 write data", 64'(mem_data), 64'(wexp[t - lat]));
                if (mem_data !== wexp[t - lat]) bad++;
            end
            if (rd_valid === 1'b1) begin
                if (ngot < 4) got[ngot] = rd_data;
                ngot++;
            end
            if (t == 1 && span > 2) begin
                // R8: stray request while busy
                req_valid = 1'b1;
                req_write = !wr;
                req_addr  = base ^ 20'h0F0F0;
            end
            if (t == 2) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        chk(ngot == (wr ? 0 : n), "R3 returned word count", 64'(ngot), 64'(wr ? 0 : n));
        if (!wr) begin
            for (int i = 0; i < n && i < ngot; i++) begin
                chk(got[i] === mem_word(base + 20'(i)), "R3 R10 read data order",
                    64'(got[i]), 64'(mem_word(base + 20'(i))));
            end
        end
        chk(bad == 0, "R9 burst unaffected by config change", 64'(bad), 64'(0));
        burst_id++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n === 1'b1 && mem_strb_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1,
            "R1 idle strobes", {60'(0), mem_ce_n, mem_strb_n, mem_oe_n, mem_we_n}, 64'hF);
        chk(mem_be_n === 4'hF, "R1 idle byte enables", 64'(mem_be_n), 64'hF);
        chk(busy === 1'b0 && rd_valid === 1'b0, "R1 idle busy/valid", {62'(0), busy, rd_valid}, 64'(0));
        for (int w = 0; w < 2; w++)
            for (int n = 1; n <= 4; n++)
                for (int l = 0; l < 4; l++)
                    for (int h = 0; h < 2; h++)
                        for (int f = 0; f < 2; f++)
                            run_burst(w[0], n, l, h[0], f[0],
                                      (burst_id % 3 == 0) ? 20'hFFFFE : 20'(burst_id * 37),
                                      4'(burst_id * 5 + 1));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule